// File: doc/BRIEF.md
# I2C Bus Condition Unit

This block sits between an I2C-mode serial shifter and the two open-drain bus pins. A single mode input selects one of two behaviours. With the mode at 0, the pins carry the shifter's clock and data unchanged. The block also watches the synchronized bus and pulses an interrupt whenever another device or the shifter produces a start or a stop condition. With the mode at 1, the shifter is disconnected from the pins. The block then builds start, repeated-start and stop conditions itself, and it pulses the interrupt when a condition has been fully generated rather than when the bus moves.

A master uses the unit in three steps. Software raises the mode and requests a start. It drops the mode while the shifter clocks each 9-pulse byte, made of 8 data bits and one acknowledge bit. It then raises the mode again and requests a stop. Requests are one-cycle strobes that the unit latches into pending flags, and each flag is cleared when its condition completes. Every phase of a generated condition lasts a programmable number of ticks of a clock-enable input, which stands in for the baud-rate generator.

Top module: `i2c_cond_unit`

## Requirements
- R1: With genMode at 0, sclDrvLow equals the inverse of shiftScl and sdaDrvLow equals the inverse of shiftSda, where a drive-low of 1 pulls the pin to 0.
- R2: With genMode at 0, SDA falling while SCL stays high on the bus gives exactly one single-cycle irqStart pulse within five cycles.
- R3: With genMode at 0, SDA rising while SCL stays high on the bus gives exactly one single-cycle irqStop pulse within five cycles.
- R4: An SDA change while SCL is low produces no interrupt, and bus activity while genMode is 1 produces no detection interrupt.
- R5: A request strobe sets its pending output on the next clock edge. With genMode at 0 a pending request stays set and does not change the pins.
- R6: A generated start moves {sclDrvLow,sdaDrvLow} through 00, 01, 11. It then pulses irqStart and clears pendStart in the same cycle.
- R7: A generated repeated start moves {sclDrvLow,sdaDrvLow} through 10, 00, 01, 11. It then pulses irqStart and clears pendRestart.
- R8: A generated stop moves {sclDrvLow,sdaDrvLow} through 11, 01, 00. It then pulses irqStop and clears pendStop.
- R9: When several requests are pending, repeated start is served first, then start, then stop.
- R10: Each phase of a generated condition lasts phaseLen ticks of tickEn, and a phaseLen of 0 acts as 1.
- R11: After reset both pins are released, no request is pending and no interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| genMode | input | 1 | 0: shifter pass-through with detection, 1: hardware condition generation |
| tickEn | input | 1 | Clock-enable tick that paces generation phases |
| phaseLen | input | LEN_W | Ticks per generation phase (0 acts as 1) |
| reqStart | input | 1 | Strobe requesting a start condition |
| reqRestart | input | 1 | Strobe requesting a repeated start condition |
| reqStop | input | 1 | Strobe requesting a stop condition |
| shiftScl | input | 1 | Shifter clock output (1 = release) |
| shiftSda | input | 1 | Shifter data output (1 = release) |
| sclIn | input | 1 | SCL level read from the bus |
| sdaIn | input | 1 | SDA level read from the bus |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| irqStart | output | 1 | Start detected (mode 0) or start/repeated start generated (mode 1) |
| irqStop | output | 1 | Stop detected (mode 0) or stop generated (mode 1) |
| pendStart | output | 1 | Start request pending |
| pendRestart | output | 1 | Repeated start request pending |
| pendStop | output | 1 | Stop request pending |

## Verification
The hardest case to reach is three requests pending at once while the mode is 1. The unit must work through them in priority order, and each pending flag must drop only when its own condition finishes. The bench strobes all three requests in one cycle. It then records the order of the completion interrupts and reads the pending flags after each one. A second hard case is a phase stretched by a sparse clock-enable. The bench toggles tickEn every other cycle and measures how long the SDA-low, SCL-high phase of a start lasts. It also parks a stop request while the mode is 0 and shows that the pins still follow the shifter, then raises the mode to let the stop run.

// File: rtl/i2ccu_pkg.sv
package i2ccu_pkg;

  typedef enum logic [1:0] {
    COND_START   = 2'd0,
    COND_RESTART = 2'd1,
    COND_STOP    = 2'd2
  } cond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDrv;
    logic nextSclLow;
    logic nextSdaLow;
    logic cntClear;
    logic cntInc;
    logic doneStart;
    logic doneStop;
  } strobe_t;

  // pin pattern {sclLow, sdaLow} for each step of each condition
  function automatic logic [1:0] stepPins(cond_e c, logic [1:0] s);
    logic [1:0] p;
    p = 2'b00;
    unique case (c)
      COND_START: begin
        if (s == 2'd0)      p = 2'b00;
        else if (s == 2'd1) p = 2'b01;
        else                p = 2'b11;
      end
      COND_RESTART: begin
        if (s == 2'd0)      p = 2'b10;
        else if (s == 2'd1) p = 2'b00;
        else if (s == 2'd2) p = 2'b01;
        else                p = 2'b11;
      end
      default: begin
        if (s == 2'd0)      p = 2'b11;
        else if (s == 2'd1) p = 2'b01;
        else                p = 2'b00;
      end
    endcase
    return p;
  endfunction

  function automatic logic [1:0] lastStep(cond_e c);
    return (c == COND_RESTART) ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/i2ccu_datapath.sv
module i2ccu_datapath
  import i2ccu_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genMode,
  input  logic             tickEn,
  input  logic [LEN_W-1:0] phaseLen,
  input  logic             shiftScl,
  input  logic             shiftSda,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  strobe_t          strb,
  output logic             cntDone,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             irqStart,
  output logic             irqStop
);

  localparam int CNT_W = LEN_W + 1;

  // bus synchronizers
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else if (g == 0) begin
          sclPipe[g] <= sclIn;
          sdaPipe[g] <= sdaIn;
        end else begin
          sclPipe[g] <= sclPipe[(g == 0) ? 0 : g-1];
          sdaPipe[g] <= sdaPipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic detStart, detStop;
  assign detStart = sclS && sclPrev && sdaPrev && !sdaS;
  assign detStop  = sclS && sclPrev && !sdaPrev && sdaS;

  // interrupt source selected by mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStart <= 1'b0;
      irqStop  <= 1'b0;
    end else if (genMode) begin
      irqStart <= strb.doneStart;
      irqStop  <= strb.doneStop;
    end else begin
      irqStart <= detStart;
      irqStop  <= detStop;
    end
  end

  // phase tick counter
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] effLen;
  logic [CNT_W-1:0] cntPlus;

  assign effLen  = (phaseLen == '0) ? LEN_W'(1) : phaseLen;
  assign cntPlus = {1'b0, cnt} + CNT_W'(1);
  assign cntDone = (cntPlus >= {1'b0, effLen});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntInc)   cnt <= cntPlus[LEN_W-1:0];
  end

  // generated pin levels
  logic sclLowQ, sdaLowQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else if (strb.loadDrv) begin
      sclLowQ <= strb.nextSclLow;
      sdaLowQ <= strb.nextSdaLow;
    end
  end

  assign sclDrvLow = genMode ? sclLowQ : !shiftScl;
  assign sdaDrvLow = genMode ? sdaLowQ : !shiftSda;

  // R6
  start_end_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneStart |-> (sclLowQ && sdaLowQ));

  // R8
  stop_end_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneStop |-> (!sclLowQ && !sdaLowQ));

  // R2
  one_irq_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqStart && irqStop));

  // R4
  det_needs_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqStart) && !$past(genMode)) |-> $past(sclS));

endmodule

// File: rtl/i2ccu_ctrl.sv
module i2ccu_ctrl
  import i2ccu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    genMode,
  input  logic    tickEn,
  input  logic    reqStart,
  input  logic    reqRestart,
  input  logic    reqStop,
  input  logic    cntDone,
  output strobe_t strb,
  output logic    pendStart,
  output logic    pendRestart,
  output logic    pendStop
);

  logic       running;
  cond_e      cond, selCond;
  logic [1:0] step;
  logic       anyPend, launch, finish, advance;

  assign anyPend = pendStart || pendRestart || pendStop;

  // fixed priority: repeated start, start, stop
  always_comb begin
    if (pendRestart)    selCond = COND_RESTART;
    else if (pendStart) selCond = COND_START;
    else                selCond = COND_STOP;
  end

  assign launch  = !running && genMode && anyPend;
  assign finish  = running && genMode && tickEn && cntDone && (step == lastStep(cond));
  assign advance = running && genMode && tickEn && cntDone && (step != lastStep(cond));

  always_comb begin
    logic [1:0] pins;
    strb = '0;
    pins = 2'b00;
    if (launch) begin
      pins          = stepPins(selCond, 2'd0);
      strb.loadDrv  = 1'b1;
      strb.cntClear = 1'b1;
    end else if (advance) begin
      pins          = stepPins(cond, step + 2'd1);
      strb.loadDrv  = 1'b1;
      strb.cntClear = 1'b1;
    end else if (running && genMode && tickEn && !cntDone) begin
      strb.cntInc = 1'b1;
    end
    strb.nextSclLow = pins[1];
    strb.nextSdaLow = pins[0];
    strb.doneStart  = finish && (cond != COND_STOP);
    strb.doneStop   = finish && (cond == COND_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cond    <= COND_START;
      step    <= 2'd0;
    end else if (launch) begin
      running <= 1'b1;
      cond    <= selCond;
      step    <= 2'd0;
    end else if (running && !genMode) begin
      running <= 1'b0;
    end else if (finish) begin
      running <= 1'b0;
    end else if (advance) begin
      step <= step + 2'd1;
    end
  end

  logic clrStart, clrRestart, clrStop;
  assign clrStart   = finish && (cond == COND_START);
  assign clrRestart = finish && (cond == COND_RESTART);
  assign clrStop    = finish && (cond == COND_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendStart   <= 1'b0;
      pendRestart <= 1'b0;
      pendStop    <= 1'b0;
    end else begin
      pendStart   <= (pendStart   && !clrStart)   || reqStart;
      pendRestart <= (pendRestart && !clrRestart) || reqRestart;
      pendStop    <= (pendStop    && !clrStop)    || reqStop;
    end
  end

  // R9
  prio_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && genMode && pendRestart) |=> (running && cond == COND_RESTART));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendStart) |-> $past(strb.doneStart));

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendStop) |-> $past(strb.doneStop));

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (step <= lastStep(cond)));

  // R5
  idle_in_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!genMode && !running) |=> !strb.loadDrv || genMode);

endmodule

// File: rtl/i2c_cond_unit.sv
module i2c_cond_unit
  import i2ccu_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genMode,
  input  logic             tickEn,
  input  logic [LEN_W-1:0] phaseLen,
  input  logic             reqStart,
  input  logic             reqRestart,
  input  logic             reqStop,
  input  logic             shiftScl,
  input  logic             shiftSda,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             irqStart,
  output logic             irqStop,
  output logic             pendStart,
  output logic             pendRestart,
  output logic             pendStop
);

  strobe_t strb;
  logic    cntDone;

  i2ccu_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .genMode    (genMode),
    .tickEn     (tickEn),
    .reqStart   (reqStart),
    .reqRestart (reqRestart),
    .reqStop    (reqStop),
    .cntDone    (cntDone),
    .strb       (strb),
    .pendStart  (pendStart),
    .pendRestart(pendRestart),
    .pendStop   (pendStop)
  );

  i2ccu_datapath #(
    .LEN_W      (LEN_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .genMode  (genMode),
    .tickEn   (tickEn),
    .phaseLen (phaseLen),
    .shiftScl (shiftScl),
    .shiftSda (shiftSda),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .cntDone  (cntDone),
    .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow),
    .irqStart (irqStart),
    .irqStop  (irqStop)
  );

endmodule

// File: tb/test_i2c_cond_unit.sv
module test_i2c_cond_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genMode = 1'b0, tickEn = 1'b1, tickSlow = 1'b0;
  logic [7:0] phaseLen = 8'd3;
  logic reqStart = 1'b0, reqRestart = 1'b0, reqStop = 1'b0;
  logic shiftScl = 1'b1, shiftSda = 1'b1;
  logic extScl = 1'b1, extSda = 1'b1;
  logic sclBus, sdaBus;
  logic sclDrvLow, sdaDrvLow, irqStart, irqStop;
  logic pendStart, pendRestart, pendStop;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  assign sclBus = extScl & ~sclDrvLow;
  assign sdaBus = extSda & ~sdaDrvLow;

  i2c_cond_unit i_i2c_cond_unit (
    .clk(clk), .rstN(rstN), .genMode(genMode), .tickEn(tickEn), .phaseLen(phaseLen),
    .reqStart(reqStart), .reqRestart(reqRestart), .reqStop(reqStop),
    .shiftScl(shiftScl), .shiftSda(shiftSda), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .irqStart(irqStart), .irqStop(irqStop),
    .pendStart(pendStart), .pendRestart(pendRestart), .pendStop(pendStop)
  );

  always @(negedge clk) tickEn <= tickSlow ? ~tickEn : 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // detection vectors: {mode, scl, sda, expStart, expStop}
  localparam int NV = 15;
  localparam logic [4:0] VEC [NV] = '{
    5'b0_1_0_1_0, // R2 start
    5'b0_0_0_0_0,
    5'b0_0_1_0_0, // R4 data change with SCL low
    5'b0_1_1_0_0,
    5'b0_1_0_1_0, // R2
    5'b0_1_1_0_1, // R3 stop
    5'b1_1_0_0_0, // R4 suppressed in generation mode
    5'b1_1_1_0_0, // R4
    5'b0_1_1_0_0,
    5'b0_0_1_0_0,
    5'b0_1_1_0_0,
    5'b0_1_0_1_0, // R2
    5'b0_0_0_0_0,
    5'b0_1_0_0_0,
    5'b0_1_1_0_1  // R3
  };

  task automatic pulseReq(input bit s, input bit r, input bit p);
    @(negedge clk);
    reqStart = s; reqRestart = r; reqStop = p;
    @(negedge clk);
    reqStart = 1'b0; reqRestart = 1'b0; reqStop = 1'b0;
  endtask

  // run one generated condition; sel 0 start, 1 restart, 2 stop
  task automatic genRun(input int sel, input logic [11:0] expSeq, input int expN,
                        input bit expStopIrq, input string tag, output int cnt01);
    logic [11:0] seq;
    logic [1:0]  last;
    int n;
    bit gotStart, gotStop;
    seq = '0; n = 1; cnt01 = 0; gotStart = 0; gotStop = 0;
    last = {sclDrvLow, sdaDrvLow};
    seq = {10'b0, last};
    pulseReq(sel == 0, sel == 1, sel == 2);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] st;
      st = {sclDrvLow, sdaDrvLow};
      if (st != last) begin
        seq = {seq[9:0], st};
        n++;
        last = st;
      end
      if (st == 2'b01) cnt01++;
      if (irqStart || irqStop) begin
        gotStart = irqStart; gotStop = irqStop;
        break;
      end
      @(negedge clk);
    end
    check(seq == expSeq && n == expN, {tag, " pin sequence"}, seq, expSeq);
    check(gotStop == expStopIrq && gotStart == !expStopIrq, {tag, " irq kind"},
          {gotStart, gotStop}, {!expStopIrq, expStopIrq});
    check({pendRestart, pendStart, pendStop} == 3'b000, {tag, " pending cleared"},
          {pendRestart, pendStart, pendStop}, 0);
  endtask

  initial begin
    int d;
    int sc, pc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({sclDrvLow, sdaDrvLow} == 2'b00, "R11 pins released", {sclDrvLow, sdaDrvLow}, 0);
    check({pendRestart, pendStart, pendStop, irqStart, irqStop} == 5'b0, "R11 idle flags",
          {pendRestart, pendStart, pendStop, irqStart, irqStop}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: detection R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      genMode = VEC[v][4]; extScl = VEC[v][3]; extSda = VEC[v][2];
      sc = 0; pc = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (irqStart) sc++;
        if (irqStop) pc++;
      end
      check(sc == int'(VEC[v][1]), $sformatf("R2/R4 vector %0d start count", v), sc, VEC[v][1]);
      check(pc == int'(VEC[v][0]), $sformatf("R3/R4 vector %0d stop count", v), pc, VEC[v][0]);
    end
    extScl = 1'b1; extSda = 1'b1;

    // R1 pass-through
    genMode = 1'b0; shiftScl = 1'b0; shiftSda = 1'b1;
    @(negedge clk);
    check({sclDrvLow, sdaDrvLow} == 2'b10, "R1 pass scl low", {sclDrvLow, sdaDrvLow}, 2'b10);
    shiftSda = 1'b0;
    @(negedge clk);
    check({sclDrvLow, sdaDrvLow} == 2'b11, "R1 pass both low", {sclDrvLow, sdaDrvLow}, 2'b11);
    shiftScl = 1'b1; shiftSda = 1'b1;
    repeat (5) @(negedge clk);

    // generation R6 R7 R8
    genMode = 1'b1; phaseLen = 8'd3;
    repeat (2) @(negedge clk);
    genRun(0, 12'b00_01_11, 3, 1'b0, "R6 start", d);
    check(d == 3, "R10 phase length 3", d, 3);
    genRun(2, 12'b11_01_00, 3, 1'b1, "R8 stop", d);
    genRun(0, 12'b00_01_11, 3, 1'b0, "R6 start again", d);
    genRun(1, 12'b11_10_00_01_11, 5, 1'b0, "R7 restart", d);
    genRun(2, 12'b11_01_00, 3, 1'b1, "R8 stop after restart", d);

    // R9 priority
    pulseReq(1'b1, 1'b1, 1'b1);
    begin
      int k;
      logic [5:0] order;
      k = 0; order = '0;
      for (int i = 0; i < 400 && k < 3; i++) begin
        if (irqStart || irqStop) begin
          order = {order[3:0], irqStart, irqStop};
          if (k == 0)
            check({pendRestart, pendStart, pendStop} == 3'b011, "R9 after first",
                  {pendRestart, pendStart, pendStop}, 3'b011);
          if (k == 1)
            check({pendRestart, pendStart, pendStop} == 3'b001, "R9 after second",
                  {pendRestart, pendStart, pendStop}, 3'b001);
          k++;
        end
        @(negedge clk);
      end
      check(order == 6'b10_10_01, "R9 irq order", order, 6'b101001);
      check({pendRestart, pendStart, pendStop} == 3'b000, "R9 all served",
            {pendRestart, pendStart, pendStop}, 0);
    end

    // R10 phaseLen 0 acts as 1, slow tick doubles length
    phaseLen = 8'd0;
    genRun(0, 12'b00_01_11, 3, 1'b0, "R10 len0 start", d);
    check(d == 1, "R10 phase length 0", d, 1);
    genRun(2, 12'b11_01_00, 3, 1'b1, "R10 len0 stop", d);
    phaseLen = 8'd4; tickSlow = 1'b1;
    genRun(0, 12'b00_01_11, 3, 1'b0, "R10 slow start", d);
    check(d == 8, "R10 slow tick length", d, 8);
    genRun(2, 12'b11_01_00, 3, 1'b1, "R10 slow stop", d);
    tickSlow = 1'b0; phaseLen = 8'd2;

    // R5 request held in pass-through mode
    genMode = 1'b0; shiftScl = 1'b0;
    @(negedge clk);
    shiftSda = 1'b0;
    pulseReq(1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check(pendStop == 1'b1, "R5 stop pending held", pendStop, 1);
    check({sclDrvLow, sdaDrvLow} == 2'b11, "R5 pins follow shifter", {sclDrvLow, sdaDrvLow}, 2'b11);
    genMode = 1'b1;
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
        @(negedge clk);
        if (irqStop) seen = 1;
      end
      check(seen, "R5 stop runs in generation mode", seen, 1);
      check(pendStop == 1'b0, "R5 pending cleared", pendStop, 0);
      check({sclDrvLow, sdaDrvLow} == 2'b00, "R8 bus released", {sclDrvLow, sdaDrvLow}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule